// File: doc/BRIEF.md
# Fetch Address Selection and Next-Address Prediction

This block decides, every cycle, which address the fetch stage of a five-stage in-order pipeline reads from, and it guesses the address of the instruction that will follow. The guess is kept in a small register. It is overwritten only when the fetch stage is free to move on, and it is held while the fetch stage is stalled.

The guess depends on the kind of instruction being fetched. Ordinary instructions fall through to the incremented address. Calls and jumps go to their constant target, and conditional jumps are always assumed to be taken. A return gets no real guess. When a guess turns out to be wrong, a later stage sends the correct address back to this block. A conditional jump that was not taken is seen in the memory stage, which returns the fall-through address it carried down the pipeline. A return is seen in the write-back stage, which returns the address loaded from the stack. Instruction memory and decoding are outside this block, so the instruction code and the two address fields arrive as plain inputs.

Top module: `fetch_pc_unit`

## Requirements
- R1: While `rst` is high the prediction register loads zero, so after reset `pred_pc` is 0. With no correction present, `f_pc` is then also 0.
- R2: When `stall` is low and the fetched code is neither jump (7) nor call (8), `pred_pc` takes `f_valp` at the next rising edge.
- R3: When `stall` is low and the fetched code is jump (7) or call (8), `pred_pc` takes `f_valc` at the next rising edge. A conditional jump is handled the same way.
- R4: A fetched return (code 9) is not predicted. Its `pred_pc` is the fall-through `f_valp`.
- R5: When `m_icode` is jump (7) and `m_bch` is 0, `f_pc` equals `m_vala` in the same cycle.
- R6: When `w_icode` is return (9) and no R5 correction is present, `f_pc` equals `w_valm` in the same cycle.
- R7: When the R5 and R6 conditions hold together, the R5 correction wins and `f_pc` equals `m_vala`.
- R8: With neither correction present, `f_pc` equals `pred_pc`.
- R9: When `stall` is high, `pred_pc` keeps its value across the rising edge, whatever the fetch inputs are.
- R10: A jump in the memory stage with `m_bch` equal to 1 is a correct guess. It causes no correction, and `f_pc` stays equal to `pred_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold the prediction register |
| f_icode | input | 4 | Code of the instruction being fetched |
| f_valp | input | PC_W | Incremented (fall-through) address of the fetched instruction |
| f_valc | input | PC_W | Constant target field of the fetched instruction |
| m_icode | input | 4 | Code of the instruction in the memory stage |
| m_bch | input | 1 | Branch-taken flag of the memory-stage instruction |
| m_vala | input | PC_W | Fall-through address carried by the memory-stage instruction |
| w_icode | input | 4 | Code of the instruction in the write-back stage |
| w_valm | input | PC_W | Value loaded by the write-back instruction (return target) |
| f_pc | output | PC_W | Address selected for fetch this cycle |
| pred_pc | output | PC_W | Registered next-address prediction |

## Verification
`f_pc` is combinational, so it is due in the same cycle as the inputs that select it. The bench drives inputs on the falling edge and checks `f_pc` 1 ns later, before the next rising edge. `pred_pc` passes through one register and is due one rising edge after the fetch inputs. The bench checks it 1 ns after that edge, against a model that is updated only on edges where `stall` is low. The correction inputs and the fetch inputs are set on the same cycle, so each cycle checks a selection and a prediction together.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int ICODE_W = 4;

  typedef enum logic [ICODE_W-1:0] {
    OP_HALT  = 4'd0,
    OP_NOP   = 4'd1,
    OP_RRMOV = 4'd2,
    OP_IRMOV = 4'd3,
    OP_RMMOV = 4'd4,
    OP_MRMOV = 4'd5,
    OP_ALU   = 4'd6,
    OP_JUMP  = 4'd7,
    OP_CALL  = 4'd8,
    OP_RET   = 4'd9,
    OP_PUSH  = 4'd10,
    OP_POP   = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    SRC_PRED   = 2'd0,
    SRC_FALLTH = 2'd1,
    SRC_RETADR = 2'd2
  } pc_src_e;
endpackage

// File: rtl/fpc_predict.sv
module fpc_predict
  import fpc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [ICODE_W-1:0] icode,
  input  logic [PC_W-1:0]    valp,
  input  logic [PC_W-1:0]    valc,
  output logic [PC_W-1:0]    guess
);
  logic use_target;

  // Jumps (any condition, assumed taken) and calls go to the constant target.
  always_comb begin
    unique case (icode)
      OP_JUMP, OP_CALL: use_target = 1'b1;
      default:          use_target = 1'b0;
    endcase
  end

  // Returns are not predicted: they fall through like plain instructions.
  assign guess = use_target ? valc : valp;
endmodule

// File: rtl/fpc_select.sv
module fpc_select
  import fpc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0]    pred_q,
  input  logic [ICODE_W-1:0] m_icode,
  input  logic               m_bch,
  input  logic [PC_W-1:0]    m_vala,
  input  logic [ICODE_W-1:0] w_icode,
  input  logic [PC_W-1:0]    w_valm,
  output pc_src_e            src,
  output logic [PC_W-1:0]    pc
);
  logic wrong_jump;
  logic ret_done;

  assign wrong_jump = (m_icode == OP_JUMP) && !m_bch;
  assign ret_done   = (w_icode == OP_RET);

  // The memory-stage fix-up outranks the write-back return target.
  always_comb begin
    if (wrong_jump)    src = SRC_FALLTH;
    else if (ret_done) src = SRC_RETADR;
    else               src = SRC_PRED;
  end

  always_comb begin
    unique case (src)
      SRC_FALLTH: pc = m_vala;
      SRC_RETADR: pc = w_valm;
      default:    pc = pred_q;
    endcase
  end
endmodule

// File: rtl/fpc_pred_reg.sv
module fpc_pred_reg #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RST_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= RST_ADDR;
    else if (!stall) q <= d;
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(q));
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
  import fpc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [3:0]      f_icode,
  input  logic [PC_W-1:0] f_valp,
  input  logic [PC_W-1:0] f_valc,
  input  logic [3:0]      m_icode,
  input  logic            m_bch,
  input  logic [PC_W-1:0] m_vala,
  input  logic [3:0]      w_icode,
  input  logic [PC_W-1:0] w_valm,
  output logic [PC_W-1:0] f_pc,
  output logic [PC_W-1:0] pred_pc
);
  logic [PC_W-1:0] guess;
  pc_src_e         src;

  fpc_predict #(.PC_W(PC_W)) predict_i (
    .icode (f_icode),
    .valp  (f_valp),
    .valc  (f_valc),
    .guess (guess)
  );

  fpc_pred_reg #(.PC_W(PC_W), .RST_ADDR('0)) pred_reg_i (
    .clk   (clk),
    .rst   (rst),
    .stall (stall),
    .d     (guess),
    .q     (pred_pc)
  );

  fpc_select #(.PC_W(PC_W)) select_i (
    .pred_q  (pred_pc),
    .m_icode (m_icode),
    .m_bch   (m_bch),
    .m_vala  (m_vala),
    .w_icode (w_icode),
    .w_valm  (w_valm),
    .src     (src),
    .pc      (f_pc)
  );

  // R5 R7
  fallthru_fix_chk: assert property (@(posedge clk) disable iff (rst)
    (m_icode == OP_JUMP && !m_bch) |-> (f_pc == m_vala));

  // R6
  ret_fix_chk: assert property (@(posedge clk) disable iff (rst)
    (w_icode == OP_RET && !(m_icode == OP_JUMP && !m_bch)) |-> (f_pc == w_valm));

  // R8 R10
  no_fix_chk: assert property (@(posedge clk) disable iff (rst)
    (!(m_icode == OP_JUMP && !m_bch) && w_icode != OP_RET) |-> (f_pc == pred_pc));

  // R3
  target_pred_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && (f_icode == OP_JUMP || f_icode == OP_CALL)) |=> (pred_pc == $past(f_valc)));

  // R2 R4
  fallthru_pred_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && f_icode != OP_JUMP && f_icode != OP_CALL) |=> (pred_pc == $past(f_valp)));
endmodule

// File: tb/fetch_pc_unit_tb.sv
module fetch_pc_unit_tb_top;
  localparam int PC_W = 32;
  localparam logic [3:0] C_NOP = 4'd1, C_IRMOV = 4'd3, C_ALU = 4'd6, C_JUMP = 4'd7,
                         C_CALL = 4'd8, C_RET = 4'd9, C_MRMOV = 4'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic [3:0] f_icode = C_NOP, m_icode = C_NOP, w_icode = C_NOP;
  logic m_bch = 1'b0;
  logic [PC_W-1:0] f_valp = '0, f_valc = '0, m_vala = '0, w_valm = '0;
  logic [PC_W-1:0] f_pc, pred_pc;

  int total = 0;
  int bad = 0;
  logic [PC_W-1:0] exp_pred = '0;

  always #2 clk = ~clk;

  fetch_pc_unit #(.PC_W(PC_W)) dut_i (
    .clk(clk), .rst(rst), .stall(stall),
    .f_icode(f_icode), .f_valp(f_valp), .f_valc(f_valc),
    .m_icode(m_icode), .m_bch(m_bch), .m_vala(m_vala),
    .w_icode(w_icode), .w_valm(w_valm),
    .f_pc(f_pc), .pred_pc(pred_pc)
  );

  task automatic check(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive after a falling edge, check f_pc before the rising edge,
  // then check pred_pc just after it.
  task automatic cyc(input logic [3:0] fi, input logic [PC_W-1:0] fp, input logic [PC_W-1:0] fc,
                     input logic [3:0] mi, input logic mb, input logic [PC_W-1:0] ma,
                     input logic [3:0] wi, input logic [PC_W-1:0] wm, input logic st,
                     input string sel_req, input string pred_req);
    logic [PC_W-1:0] exp_pc;
    f_icode = fi; f_valp = fp; f_valc = fc;
    m_icode = mi; m_bch = mb; m_vala = ma;
    w_icode = wi; w_valm = wm; stall = st;
    #1;
    if (mi == C_JUMP && !mb) exp_pc = ma;
    else if (wi == C_RET)    exp_pc = wm;
    else                     exp_pc = exp_pred;
    check(sel_req, f_pc, exp_pc);
    @(posedge clk);
    if (!st) exp_pred = (fi == C_JUMP || fi == C_CALL) ? fc : fp;
    #1;
    check(pred_req, pred_pc, exp_pred);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_pred = '0;
    check("R1 pred_pc", pred_pc, '0);
    check("R1 f_pc", f_pc, '0);
    rst = 1'b0;
  endtask

  task automatic t_straight;
    cyc(C_IRMOV, 32'h6,  32'h1111, C_NOP, 1'b0, 32'h0, C_NOP, 32'h0, 1'b0, "R8 straight", "R2 irmov");
    cyc(C_NOP,   32'h7,  32'h2222, C_ALU, 1'b1, 32'h0, C_NOP, 32'h0, 1'b0, "R8 straight", "R2 nop");
    cyc(C_ALU,   32'h9,  32'h3333, C_NOP, 1'b0, 32'h0, C_ALU, 32'h5, 1'b0, "R8 straight", "R2 alu");
    cyc(C_MRMOV, 32'hF,  32'h4444, C_NOP, 1'b0, 32'h0, C_NOP, 32'h0, 1'b0, "R8 straight", "R2 mrmov");
  endtask

  task automatic t_taken;
    cyc(C_JUMP, 32'h14, 32'h40, C_NOP, 1'b0, 32'h0, C_NOP, 32'h0, 1'b0, "R8 jump fetch", "R3 jump");
    cyc(C_CALL, 32'h45, 32'h80, C_NOP, 1'b0, 32'h0, C_NOP, 32'h0, 1'b0, "R8 jump target", "R3 call");
    cyc(C_NOP,  32'h81, 32'h0,  C_JUMP, 1'b1, 32'hDEAD, C_NOP, 32'h0, 1'b0, "R10 taken jump", "R2 after call");
  endtask

  task automatic t_not_taken;
    cyc(C_JUMP, 32'h87, 32'h200, C_NOP, 1'b0, 32'h0, C_NOP, 32'h0, 1'b0, "R8 cond jump", "R3 cond jump");
    cyc(C_IRMOV, 32'h206, 32'h0, C_JUMP, 1'b0, 32'h87, C_NOP, 32'h0, 1'b0, "R5 not taken", "R2 fix fetch");
    cyc(C_NOP, 32'h88, 32'h0, C_NOP, 1'b0, 32'h0, C_NOP, 32'h0, 1'b0, "R8 after fix", "R2 resume");
  endtask

  task automatic t_return;
    cyc(C_RET, 32'h27, 32'h5555, C_NOP, 1'b0, 32'h0, C_NOP, 32'h0, 1'b0, "R8 ret fetch", "R4 ret");
    cyc(C_NOP, 32'h28, 32'h0, C_NOP, 1'b0, 32'h0, C_RET, 32'h0B, 1'b0, "R6 ret target", "R2 after ret");
    cyc(C_NOP, 32'h2C, 32'h0, C_RET, 1'b0, 32'h0, C_RET, 32'h31, 1'b0, "R6 ret with mem ret", "R2 next");
  endtask

  task automatic t_combo;
    cyc(C_NOP, 32'h30, 32'h0, C_JUMP, 1'b0, 32'h77, C_RET, 32'h99, 1'b0, "R7 priority", "R2 combo");
    cyc(C_NOP, 32'h31, 32'h0, C_JUMP, 1'b1, 32'h77, C_RET, 32'hAB, 1'b0, "R6 R10 taken with ret", "R2 combo2");
  endtask

  task automatic t_stall;
    cyc(C_IRMOV, 32'h50, 32'h0, C_NOP, 1'b0, 32'h0, C_NOP, 32'h0, 1'b0, "R8 pre stall", "R2 pre stall");
    cyc(C_CALL, 32'h60, 32'h999, C_NOP, 1'b0, 32'h0, C_NOP, 32'h0, 1'b1, "R8 stalled", "R9 hold call");
    cyc(C_NOP, 32'h61, 32'h0, C_NOP, 1'b0, 32'h0, C_NOP, 32'h0, 1'b1, "R8 stalled", "R9 hold nop");
    cyc(C_JUMP, 32'h62, 32'h300, C_NOP, 1'b0, 32'h0, C_NOP, 32'h0, 1'b0, "R8 unstall", "R3 after stall");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_straight();
    t_taken();
    t_not_taken();
    t_return();
    t_combo();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule